// File: doc/BRIEF.md
# Sampling Converter Sequencer with Early Interrupt Placement

This block reproduces the timing of a sampling analog-to-digital converter without its analog path. A trigger received while the block is idle opens a sample-and-hold acquisition window. The window lasts a programmable number of clock cycles. A conversion phase of fixed length follows it. When the conversion completes, the block captures the digitized sample presented on its input into a result register and raises a valid flag.

A single one-cycle interrupt pulse accompanies every conversion. It can sit in one of two places. In the first, it coincides with the result landing. In the second, it comes early: a programmed number of cycles after the acquisition window closes. This lets a consumer such as a control-loop engine start its preparatory work early and read the result just as it becomes available. A typical early setting is an offset of 20 cycles against a 42-cycle conversion. An offset that reaches or passes the conversion length is clamped so that the pulse fires with the result.

Triggers usually come once per period of an external PWM-derived timebase. A trigger that arrives while a conversion is in flight is dropped, and a sticky overrun flag records it until software writes a one to clear it.

Top module: `sampler_irq_gen`

## Requirements
- R1: While and after reset, `irq_o`, `busy_o`, `result_vld_o` and `overrun_o` are 0 and `result_o` is all zeros.
- R2: A trigger sampled high on a clock edge while idle starts a conversion. Let A = `acq_len_i` at that edge, with 0 treated as 1, and C = `CONV_CYC`. `busy_o` is high from the cycle after that edge for exactly A + C cycles.
- R3: On the edge that ends the conversion, `result_o` takes the `sample_i` value present at that edge and `result_vld_o` becomes 1 in the same cycle. `result_o` changes on no other edge. `result_vld_o` stays 1 until the next accepted trigger clears it, so it is 0 whenever `busy_o` is 1.
- R4: End-of-conversion placement is selected when `early_mode_i` = 0 at the trigger. In this placement `irq_o` is high for exactly one cycle per conversion: the first cycle in which the new result is visible.
- R5: Early placement is selected when `early_mode_i` = 1 at the trigger. Let t0 be the first busy cycle and K = `irq_ofs_i` with K < C. `irq_o` is high for exactly one cycle, cycle t0 + A + K. K = 0 places it in the first conversion cycle.
- R6: In early placement with K >= C, the pulse is clamped to cycle t0 + A + C, the same cycle the result appears.
- R7: A trigger sampled high while `busy_o` is 1 is ignored: busy length, pulse position and result are unchanged. `overrun_o` is 1 from the next cycle.
- R8: `overrun_o` is sticky and is cleared by `ovr_clr_i` = 1 on an edge. If a new overrun and a clear occur on the same edge, the overrun wins.
- R9: Mode, offset and acquisition length are captured at the accepted trigger. Changing them while busy does not affect the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start-of-conversion trigger, sampled each edge |
| acq_len_i | input | ACQ_W | Acquisition window length in cycles (0 acts as 1) |
| early_mode_i | input | 1 | 1 = early pulse placement, 0 = pulse at end of conversion |
| irq_ofs_i | input | OFS_W | Early pulse offset after acquisition end, in cycles |
| sample_i | input | DATA_W | Digitized sample captured when conversion ends |
| ovr_clr_i | input | 1 | Write-one clear of the overrun flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| result_o | output | DATA_W | Result register |
| result_vld_o | output | 1 | Result valid flag |
| busy_o | output | 1 | Acquisition or conversion in progress |
| overrun_o | output | 1 | Sticky flag: trigger arrived while busy |

## Verification
The bench sweeps acquisition lengths including 0 and 1, together with offsets just below, at and above the conversion length and the typical value 20. It does this in both placements and checks where the single pulse falls. An off-by-one counter would move the pulse a cycle early or late, and a missing clamp would put it after the result or drop it altogether. It also injects triggers mid-conversion together with a simultaneous overrun clear, and it changes mode and offset while busy. A design that restarted on a busy trigger, let clear beat set, or read live configuration would shift the busy window or the pulse. It also checks that the valid flag drops as a new conversion starts and that the captured sample is the one present on the final conversion edge, not one cycle before or after.

// File: rtl/sampler_irq_pkg.sv
package sampler_irq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;
endpackage

// File: rtl/sampler_phase_seq.sv
module sampler_phase_seq
  import sampler_irq_pkg::*;
#(
  parameter int ACQ_W    = 8,
  parameter int CONV_CYC = 42
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [ACQ_W-1:0] acq_len_i,
  output phase_e           phase_o,
  output logic             acq_end_o,
  output logic             conv_end_o
);
  localparam int CONV_W = $clog2(CONV_CYC + 1);
  localparam int CNT_W  = (ACQ_W > CONV_W) ? ACQ_W : CONV_W;

  phase_e           ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start_i) begin
            ph  <= PH_ACQ;
            cnt <= (acq_len_i == '0) ? '0 : CNT_W'(acq_len_i) - CNT_W'(1);
          end
        end
        PH_ACQ: begin
          if (cnt == '0) begin
            ph  <= PH_CONV;
            cnt <= CNT_W'(CONV_CYC - 1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_CONV: begin
          if (cnt == '0) begin
            ph <= PH_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = ph;
  assign acq_end_o  = (ph == PH_ACQ)  && (cnt == '0);
  assign conv_end_o = (ph == PH_CONV) && (cnt == '0);
endmodule

// File: rtl/sampler_irq_place.sv
module sampler_irq_place #(
  parameter int CONV_CYC = 42,
  parameter int OFS_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             early_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             acq_end_i,
  input  logic             conv_end_i,
  output logic             irq_o,
  output logic             early_q_o
);
  localparam int CONV_W = $clog2(CONV_CYC + 1);
  localparam int DLY_W  = (OFS_W > CONV_W) ? OFS_W : CONV_W;

  logic             early_q;
  logic [OFS_W-1:0] ofs_q;
  logic [DLY_W-1:0] eff;
  logic [DLY_W-1:0] dly;
  logic             armed;
  logic             irq_q;

  // clamp the programmed offset to the conversion length
  always_comb begin
    eff = DLY_W'(ofs_q);
    if (eff >= DLY_W'(CONV_CYC)) eff = DLY_W'(CONV_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      ofs_q   <= '0;
      dly     <= '0;
      armed   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (start_i) begin
        early_q <= early_i;
        ofs_q   <= ofs_i;
        armed   <= 1'b0;
      end
      if (early_q) begin
        if (acq_end_i) begin
          if (eff == '0) begin
            irq_q <= 1'b1;
          end else begin
            armed <= 1'b1;
            dly   <= eff;
          end
        end else if (armed) begin
          if (dly == DLY_W'(1)) begin
            irq_q <= 1'b1;
            armed <= 1'b0;
          end
          dly <= dly - DLY_W'(1);
        end
      end else if (conv_end_i) begin
        irq_q <= 1'b1;
      end
    end
  end

  assign irq_o     = irq_q;
  assign early_q_o = early_q;
endmodule

// File: rtl/sampler_result_hold.sv
module sampler_result_hold #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] result_o,
  output logic              vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      vld_o    <= 1'b0;
    end else if (load_i) begin
      result_o <= sample_i;
      vld_o    <= 1'b1;
    end else if (clear_i) begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sampler_irq_gen.sv
module sampler_irq_gen
  import sampler_irq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CONV_CYC = 42,
  parameter int ACQ_W    = 8,
  parameter int OFS_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [ACQ_W-1:0]  acq_len_i,
  input  logic              early_mode_i,
  input  logic [OFS_W-1:0]  irq_ofs_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ovr_clr_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o,
  output logic              busy_o,
  output logic              overrun_o
);
  phase_e phase;
  logic   acq_end;
  logic   conv_end;
  logic   start;
  logic   early_q;
  logic   ovr_q;

  assign busy_o = (phase != PH_IDLE);
  assign start  = trig_i && !busy_o;

  sampler_phase_seq #(.ACQ_W(ACQ_W), .CONV_CYC(CONV_CYC)) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .acq_len_i(acq_len_i),
    .phase_o(phase), .acq_end_o(acq_end), .conv_end_o(conv_end)
  );

  sampler_irq_place #(.CONV_CYC(CONV_CYC), .OFS_W(OFS_W)) u_place (
    .clk(clk), .rst(rst), .start_i(start), .early_i(early_mode_i),
    .ofs_i(irq_ofs_i), .acq_end_i(acq_end), .conv_end_i(conv_end),
    .irq_o(irq_o), .early_q_o(early_q)
  );

  sampler_result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load_i(conv_end), .clear_i(start),
    .sample_i(sample_i), .result_o(result_o), .vld_o(result_vld_o)
  );

  // sticky overrun: a new overrun beats a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
    end else if (trig_i && busy_o) begin
      ovr_q <= 1'b1;
    end else if (ovr_clr_i) begin
      ovr_q <= 1'b0;
    end
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/sampler_irq_gen_chk.sv
module sampler_irq_gen_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_i,
  input logic              ovr_clr_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] result_o,
  input logic              result_vld_o,
  input logic              busy_o,
  input logic              overrun_o,
  input logic              early_q
);
  AST_BUSY_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && trig_i) |=> busy_o); // R2
  AST_VLD_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> result_vld_o); // R3
  AST_VLD_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !result_vld_o); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy_o) |-> $stable(result_o)); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R4
  AST_EOC_IRQ_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !early_q) |-> irq_o); // R4
  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(busy_o)); // R5
  AST_OVR_ON_BUSY_TRIG: assert property (@(posedge clk) disable iff (rst)
    (busy_o && trig_i) |=> overrun_o); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !ovr_clr_i) |=> overrun_o); // R8
endmodule

bind sampler_irq_gen sampler_irq_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .trig_i(trig_i), .ovr_clr_i(ovr_clr_i),
  .irq_o(irq_o), .result_o(result_o), .result_vld_o(result_vld_o),
  .busy_o(busy_o), .overrun_o(overrun_o), .early_q(early_q)
);

// File: tb/sampler_irq_gen_bench.sv
module sampler_irq_gen_bench;
  localparam int DW   = 12;
  localparam int CONV = 42;
  localparam int AW   = 8;
  localparam int OW   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig = 1'b0;
  logic          early = 1'b0;
  logic          clr = 1'b0;
  logic [AW-1:0] acq = '0;
  logic [OW-1:0] ofs = '0;
  logic [DW-1:0] smp = '0;
  logic          irq, busy, vld, ovr;
  logic [DW-1:0] res;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  sampler_irq_gen #(.DATA_W(DW), .CONV_CYC(CONV), .ACQ_W(AW), .OFS_W(OW)) u_sampler_irq_gen (
    .clk(clk), .rst(rst), .trig_i(trig), .acq_len_i(acq), .early_mode_i(early),
    .irq_ofs_i(ofs), .sample_i(smp), .ovr_clr_i(clr), .irq_o(irq),
    .result_o(res), .result_vld_o(vld), .busy_o(busy), .overrun_o(ovr)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; inj = trigger + clear mid-conversion, chg = reprogram while busy
  task automatic run(int a, bit md, int of, bit inj, bit chg, logic [DW-1:0] pat);
    int    aeff   = (a == 0) ? 1 : a;
    int    eff    = md ? ((of > CONV) ? CONV : of) : CONV;
    int    last   = aeff + CONV + 1;
    int    irq_at = -1;
    int    irq_n  = 0;
    int    bbad   = 0;
    int    vbad   = 0;
    string rq     = !md ? "R4" : ((of >= CONV) ? "R6" : "R5");
    @(negedge clk);
    trig = 1'b1; acq = AW'(a); early = md; ofs = OW'(of); smp = pat;
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      if (i == 1) trig = 1'b0;
      if (busy !== (i <= aeff + CONV)) bbad++;
      if (irq === 1'b1) begin irq_n++; irq_at = i; end
      if (i <= aeff + CONV && vld !== 1'b0) vbad++;
      if (chg && i == 3) begin early = ~md; ofs = ~OW'(of); acq = AW'(a + 9); end
      if (inj && i == 5) begin trig = 1'b1; clr = 1'b1; end
      if (inj && i == 6) begin trig = 1'b0; clr = 1'b0; end
      smp = pat ^ DW'(i);
    end
    chk(chg ? "R9 busy window" : "R2 busy window", bbad, 0);
    chk({rq, " pulse count"}, irq_n, 1);
    chk(chg ? "R9 pulse position" : {rq, " pulse position"}, irq_at, aeff + eff + 1);
    chk("R3 result", int'(res), int'(pat ^ DW'(aeff + CONV)));
    chk("R3 valid at end", int'(vld), 1);
    chk("R3 valid low while busy", vbad, 0);
    if (inj) begin
      chk("R7 overrun set", int'(ovr), 1);
      chk("R8 set wins over clear", int'(ovr), 1);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk("R8 cleared", int'(ovr), 0);
    end else begin
      chk("R7 no spurious overrun", int'(ovr), 0);
    end
  endtask

  initial begin
    int alist[6] = '{0, 1, 2, 3, 7, 250};
    int olist[11] = '{0, 1, 2, 19, 20, 21, 40, 41, 42, 43, 200};
    repeat (4) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    trig = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 result", int'(res), 0);
    chk("R1 valid", int'(vld), 0);
    chk("R1 overrun", int'(ovr), 0);
    foreach (alist[ai]) begin
      for (int m = 0; m < 2; m++) begin
        foreach (olist[oi]) begin
          if (alist[ai] == 250 && oi % 3 != 0) continue;
          run(alist[ai], m[0], olist[oi], (oi % 2) == 1, (oi % 4) == 2,
              DW'(12'h5A3 + ai * 97 + oi * 13 + m * 701));
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      chk("WATCHDOG R2 run completion", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule